// File: doc/BRIEF.md
# Visible-Region Marker Timing Generator

This block is the free-running raster timer at the head of a video output path. On every pixel clock it advances a column position across the full frame width, and at the end of each line it advances a row position down the full frame height. From these two positions it drives two active-high flags. The horizontal flag is high while the column is inside the visible width. The vertical flag is high while the row is inside the visible height. When both flags are high, the current pixel is in the visible picture.

The raw column and row positions are also brought out so that downstream stages can find their place in the frame. A later stage turns the flags into real monitor sync pulses with porches. This block does not do that, and it does not produce colour. The frame and visible sizes are parameters. The defaults are an 800 x 525 frame with a 640 x 480 visible area, which gives 60 frames per second from a 25 MHz pixel clock.

There is no enable or start input. The generator runs from the moment reset is released. The reset input is active low and clears the block asynchronously. Its release passes through a two-stage synchronizer, so counting begins a fixed number of edges after the release.

Top module: `raster_mark_gen`

## Requirements
- R1: The column output counts up by one on every rising clock edge from 0 to FRAME_COLS-1, then returns to 0 on the next edge.
- R2: The row output holds its value within a line and advances by one on the edge where the column returns to 0. After FRAME_ROWS-1 it returns to 0 on that edge.
- R3: The horizontal flag is 1 exactly in the cycles where the column output is below VIS_COLS. It changes on the same edge as the column output.
- R4: The vertical flag is 1 exactly in the cycles where the row output is below VIS_ROWS. It changes on the same edge as the row output.
- R5: While rst_n is low, column and row are 0 and both flags are 1 (the top-left visible pixel). This state is taken as soon as rst_n falls, without waiting for a clock edge.
- R6: After rst_n rises, the outputs stay at the reset state through the first two rising edges. The column reads 1 after the third rising edge.
- R7: The position (0,0) recurs exactly every FRAME_COLS*FRAME_ROWS cycles, with no enable or start input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| h_vis | output | 1 | High while the column is inside the visible width |
| v_vis | output | 1 | High while the row is inside the visible height |
| col_pos | output | $clog2(FRAME_COLS) | Current column, 0 to FRAME_COLS-1 |
| row_pos | output | $clog2(FRAME_ROWS) | Current row, 0 to FRAME_ROWS-1 |

## Verification
Any wrong state in this block shows up at the ports within one clock. A skipped or repeated column value shows at once on col_pos. A wrong row step or a missed wrap shows on the next line boundary. A flag that is out of step with its counter breaks the flag-versus-position relation in the same cycle. Because the frame is short, a reduced configuration can be swept cycle by cycle over several whole frames and across a reset taken mid-frame. A full-size instance is checked over its first two line wraps and the visible-width edge.

// File: rtl/raster_mark_pkg.sv
package raster_mark_pkg;
  localparam int DEF_FRAME_COLS = 800;
  localparam int DEF_FRAME_ROWS = 525;
  localparam int DEF_VIS_COLS   = 640;
  localparam int DEF_VIS_ROWS   = 480;
  localparam int DEF_SYNC_STAGES = 2;

  function automatic int pos_width(input int span);
    return (span < 2) ? 1 : $clog2(span);
  endfunction
endpackage

// File: rtl/rmg_rst_sync.sv
module rmg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rmg_col_ctr.sv
module rmg_col_ctr #(
  parameter int FRAME_COLS = 800,
  localparam int CW = raster_mark_pkg::pos_width(FRAME_COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] col_q,
  output logic [CW-1:0] col_d,
  output logic          line_end
);
  localparam logic [CW-1:0] COL_LAST = CW'(FRAME_COLS - 1);

  always_comb begin
    line_end = (col_q == COL_LAST);
    col_d    = line_end ? '0 : col_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_d;
  end

  // R1
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(col_q) < FRAME_COLS);
  // R1
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q != COL_LAST) |=> (col_q == $past(col_q) + 1'b1));
  // R1
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q == COL_LAST) |=> (col_q == '0));
endmodule

// File: rtl/rmg_row_ctr.sv
module rmg_row_ctr #(
  parameter int FRAME_ROWS = 525,
  localparam int RW = raster_mark_pkg::pos_width(FRAME_ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [RW-1:0] row_q,
  output logic [RW-1:0] row_d
);
  localparam logic [RW-1:0] ROW_LAST = RW'(FRAME_ROWS - 1);

  logic row_en;

  always_comb begin
    row_en = advance;
    row_d  = row_q;
    if (row_en) row_d = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_d;
  end

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(row_q));
  // R2
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && row_q != ROW_LAST) |=> (row_q == $past(row_q) + 1'b1));
  // R2
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && row_q == ROW_LAST) |=> (row_q == '0));
endmodule

// File: rtl/rmg_vis_flags.sv
module rmg_vis_flags #(
  parameter int VIS_COLS = 640,
  parameter int VIS_ROWS = 480,
  parameter int CW = 10,
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] col_d,
  input  logic [RW-1:0] row_d,
  input  logic [CW-1:0] col_q,
  input  logic [RW-1:0] row_q,
  output logic          h_q,
  output logic          v_q
);
  localparam logic H_RST = (VIS_COLS > 0);
  localparam logic V_RST = (VIS_ROWS > 0);

  logic h_d, v_d;

  always_comb begin
    h_d = (32'(col_d) < VIS_COLS);
    v_d = (32'(row_d) < VIS_ROWS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= H_RST;
      v_q <= V_RST;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  // R3
  h_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_q == (32'(col_q) < VIS_COLS));
  // R4
  v_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_q == (32'(row_q) < VIS_ROWS));
endmodule

// File: rtl/raster_mark_gen.sv
module raster_mark_gen #(
  parameter int FRAME_COLS  = raster_mark_pkg::DEF_FRAME_COLS,
  parameter int FRAME_ROWS  = raster_mark_pkg::DEF_FRAME_ROWS,
  parameter int VIS_COLS    = raster_mark_pkg::DEF_VIS_COLS,
  parameter int VIS_ROWS    = raster_mark_pkg::DEF_VIS_ROWS,
  parameter int SYNC_STAGES = raster_mark_pkg::DEF_SYNC_STAGES,
  localparam int CW = raster_mark_pkg::pos_width(FRAME_COLS),
  localparam int RW = raster_mark_pkg::pos_width(FRAME_ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          h_vis,
  output logic          v_vis,
  output logic [CW-1:0] col_pos,
  output logic [RW-1:0] row_pos
);
  logic          core_rst_n;
  logic [CW-1:0] col_next;
  logic [RW-1:0] row_next;
  logic          wrap;

  rmg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(core_rst_n));

  rmg_col_ctr #(.FRAME_COLS(FRAME_COLS)) u_col (
    .clk(clk), .rst_n(core_rst_n), .col_q(col_pos),
    .col_d(col_next), .line_end(wrap));

  rmg_row_ctr #(.FRAME_ROWS(FRAME_ROWS)) u_row (
    .clk(clk), .rst_n(core_rst_n), .advance(wrap),
    .row_q(row_pos), .row_d(row_next));

  rmg_vis_flags #(.VIS_COLS(VIS_COLS), .VIS_ROWS(VIS_ROWS),
                  .CW(CW), .RW(RW)) u_flags (
    .clk(clk), .rst_n(core_rst_n), .col_d(col_next), .row_d(row_next),
    .col_q(col_pos), .row_q(row_pos), .h_q(h_vis), .v_q(v_vis));
endmodule

// File: tb/tb_raster_mark_gen.sv
module tb_raster_mark_gen;
  localparam int CLK_PERIOD = 40;
  localparam int TC = 10, TR = 5, AC = 6, AR = 3;
  localparam int FTC = 800, FTR = 525, FAC = 640, FAR = 480;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_s, v_s, h_f, v_f;
  logic [3:0] col_s;
  logic [2:0] row_s;
  logic [9:0] col_f, row_f;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_mark_gen #(.FRAME_COLS(TC), .FRAME_ROWS(TR), .VIS_COLS(AC), .VIS_ROWS(AR)) dut (
    .clk(clk), .rst_n(rst_n), .h_vis(h_s), .v_vis(v_s), .col_pos(col_s), .row_pos(row_s));

  raster_mark_gen dut_full (
    .clk(clk), .rst_n(rst_n), .h_vis(h_f), .v_vis(v_f), .col_pos(col_f), .row_pos(row_f));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reset_state(input string tag);
    chk({tag, " R5 col"}, int'(col_s), 0);
    chk({tag, " R5 row"}, int'(row_s), 0);
    chk({tag, " R5 h"}, int'(h_s), 1);
    chk({tag, " R5 v"}, int'(v_s), 1);
    chk({tag, " R5 full col"}, int'(col_f), 0);
    chk({tag, " R5 full row"}, int'(row_f), 0);
  endtask

  // rst_n released at a falling edge just before this task is called
  task automatic sweep(input int edges, input bit full);
    for (int k = 1; k <= edges; k++) begin
      int n, ec, er;
      @(posedge clk);
      #(CLK_PERIOD/4);
      n = (k < 3) ? 0 : k - 2;
      if (k <= 2) chk("R6 held col", int'(col_s), 0);
      if (k == 3) chk("R6 first step", int'(col_s), 1);
      ec = n % TC;
      er = (n / TC) % TR;
      chk("R1 col", int'(col_s), ec);
      chk("R2 row", int'(row_s), er);
      chk("R3 h flag", int'(h_s), (ec < AC) ? 1 : 0);
      chk("R4 v flag", int'(v_s), (er < AR) ? 1 : 0);
      if (n > 0 && n % (TC*TR) == 0)
        chk("R7 frame origin", int'(col_s) + int'(row_s), 0);
      if (full) begin
        ec = n % FTC;
        er = (n / FTC) % FTR;
        chk("R1 full col", int'(col_f), ec);
        chk("R2 full row", int'(row_f), er);
        chk("R3 full h", int'(h_f), (ec < FAC) ? 1 : 0);
        chk("R4 full v", int'(v_f), (er < FAR) ? 1 : 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    reset_state("power-up");
    @(negedge clk);
    rst_n = 1'b1;
    sweep(1800, 1'b1);
    // asynchronous reset taken mid-frame, away from any edge
    @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    reset_state("async");
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    reset_state("held");
    @(negedge clk);
    rst_n = 1'b1;
    sweep(4 * TC * TR + 7, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule